// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind a bit-level I2C receiver and decides whether the address phase of a transfer is meant for this slave. The receiver hands it START, repeated-START and STOP events plus each received byte with a one-cycle valid strobe. The block compares only the first byte after a START or repeated START. It raises an addressed-as-slave flag, or a general-call flag, and gives one interrupt pulse when either is found.

In 7-bit mode the upper seven bits of that byte are compared with the own address, and the R/W bit does not take part. In 10-bit mode the first byte is compared in full: the upper seven bits go against the own address, and the R/W bit goes against a stored RBW bit. The second address byte is left to firmware. Once firmware has matched it, firmware writes RBW to 1, so the first byte with R/W = 1 that follows a repeated START is then accepted. The block does not drive ACK and does not stretch the clock.

Top module: `slave_addr_recognizer`

## Requirements
- R1: With `tenBitMode` = 0, a first byte matches when `rxByte[7:1]` equals `ownAddr`, whatever the value of `rxByte[0]` (R/W).
- R2: With `tenBitMode` = 1, a first byte matches only when `rxByte[7:1]` equals `ownAddr` and `rxByte[0]` equals the stored RBW bit. The comparison uses the RBW value held before any write made in the same cycle.
- R3: When a first byte matches, `addrMatch` is 1 from the cycle after the byte strobe and `irqPulse` is 1 in that same cycle.
- R4: A first byte of 0x00 is a general call. It sets `genCall` to 1, leaves `addrMatch` at 0 and pulses `irqPulse`, with the same one-cycle timing as R3.
- R5: A first byte that neither matches nor is 0x00 leaves both flags at 0 and raises no interrupt.
- R6: Only the first byte strobe after a START or repeated START is evaluated. Later strobes, and strobes seen before any START, change no output.
- R7: Asserting `rbwWr` loads `rbwWrData` into the RBW bit, which is visible on `rbwOut` in the next cycle. Nothing else changes RBW except reset.
- R8: `stopEv` clears both flags in the next cycle and stops evaluation. It takes priority over a `startEv` or a byte strobe in the same cycle.
- R9: `startEv` clears both flags in the next cycle and arms evaluation of the next byte. A byte strobe in the same cycle as `startEv` is ignored.
- R10: `irqPulse` lasts exactly one cycle and occurs at most once per address phase.
- R11: While `rstN` is 0 at a clock edge, both flags, `irqPulse` and RBW go to 0, and evaluation is disarmed.
- R12: `addrMatch` and `genCall` are never 1 together, and `irqPulse` is only 1 when one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| startEv | input | 1 | One-cycle START or repeated-START event |
| stopEv | input | 1 | One-cycle STOP event |
| byteValid | input | 1 | Strobe: `rxByte` holds a received byte |
| rxByte | input | ADDR_W+1 | Received byte; bit 0 is R/W |
| ownAddr | input | ADDR_W | This slave's 7-bit address |
| tenBitMode | input | 1 | 0 selects 7-bit addressing, 1 selects 10-bit addressing |
| rbwWr | input | 1 | Software write strobe for RBW |
| rbwWrData | input | 1 | Value written to RBW |
| addrMatch | output | 1 | Addressed-as-slave flag |
| genCall | output | 1 | General-call flag |
| irqPulse | output | 1 | One-cycle interrupt request |
| rbwOut | output | 1 | Current RBW bit |

## Verification
The case that is hardest to reach from the ports is the full 10-bit handshake. First a START with R/W = 0 has to match, then a second byte has to arrive and be ignored, then firmware writes RBW, and only then does a repeated START with R/W = 1 match. The stimulus walks through that order step by step. It also sends the R/W = 1 byte while RBW is still 0, and it writes RBW in the same cycle as the byte is evaluated. Same-cycle collisions of STOP, START and byte strobes are forced directly, and a behavioural model checks every cycle.

// File: rtl/addr_rec_pkg.sv
package addr_rec_pkg;
  // Strobes issued by the control each cycle to the datapath
  typedef struct packed {
    logic clrFlags;  // STOP or START seen: drop both flags
    logic evalByte;  // this byte is the first after a START
  } ctrl_strobe_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // no START seen since STOP or reset
    PH_ARMED = 2'd1,  // waiting for first address byte
    PH_HELD  = 2'd2   // address phase decided, ignoring bytes
  } phase_t;
endpackage

// File: rtl/addr_rec_ctrl.sv
module addr_rec_ctrl
  import addr_rec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startEv,
  input  logic         stopEv,
  input  logic         byteValid,
  output ctrl_strobe_t strobes
);
  phase_t phaseQ, phaseD;

  always_comb begin
    strobes.clrFlags = stopEv | startEv;
    strobes.evalByte = !stopEv && !startEv && byteValid && (phaseQ == PH_ARMED);
    phaseD = phaseQ;
    if (stopEv)                phaseD = PH_IDLE;
    else if (startEv)          phaseD = PH_ARMED;
    else if (strobes.evalByte) phaseD = PH_HELD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseD;
  end
endmodule

// File: rtl/addr_rec_dp.sv
module addr_rec_dp
  import addr_rec_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobes,
  input  logic              tenBitMode,
  input  logic [ADDR_W:0]   rxByte,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              rbwWr,
  input  logic              rbwWrData,
  output logic              addrMatch,
  output logic              genCall,
  output logic              irqPulse,
  output logic              rbwOut
);
  localparam int BYTE_W = ADDR_W + 1;

  logic [ADDR_W-1:0] bitEq;
  logic              rbwQ, matchQ, gcQ, irqQ;
  logic              isZero, upperHit, rwHit, hit;

  // per-bit comparison of the address field against the own address
  for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
    assign bitEq[i] = ~(rxByte[i+1] ^ ownAddr[i]);
  end

  always_comb begin
    isZero   = (rxByte == {BYTE_W{1'b0}});
    upperHit = &bitEq;
    rwHit    = tenBitMode ? (rxByte[0] == rbwQ) : 1'b1;
    hit      = upperHit && rwHit && !isZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rbwQ   <= 1'b0;
      matchQ <= 1'b0;
      gcQ    <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      irqQ <= 1'b0;
      if (rbwWr) rbwQ <= rbwWrData;
      if (strobes.clrFlags) begin
        matchQ <= 1'b0;
        gcQ    <= 1'b0;
      end else if (strobes.evalByte) begin
        gcQ    <= isZero;
        matchQ <= hit;
        irqQ   <= isZero | hit;
      end
    end
  end

  assign addrMatch = matchQ;
  assign genCall   = gcQ;
  assign irqPulse  = irqQ;
  assign rbwOut    = rbwQ;
endmodule

// File: rtl/slave_addr_recognizer.sv
module slave_addr_recognizer
  import addr_rec_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              byteValid,
  input  logic [ADDR_W:0]   rxByte,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              tenBitMode,
  input  logic              rbwWr,
  input  logic              rbwWrData,
  output logic              addrMatch,
  output logic              genCall,
  output logic              irqPulse,
  output logic              rbwOut
);
  ctrl_strobe_t strobes;

  addr_rec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startEv   (startEv),
    .stopEv    (stopEv),
    .byteValid (byteValid),
    .strobes   (strobes)
  );

  addr_rec_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .tenBitMode (tenBitMode),
    .rxByte     (rxByte),
    .ownAddr    (ownAddr),
    .rbwWr      (rbwWr),
    .rbwWrData  (rbwWrData),
    .addrMatch  (addrMatch),
    .genCall    (genCall),
    .irqPulse   (irqPulse),
    .rbwOut     (rbwOut)
  );
endmodule

// File: rtl/slave_addr_recognizer_chk.sv
module slave_addr_recognizer_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              startEv,
  input logic              stopEv,
  input logic              byteValid,
  input logic [ADDR_W:0]   rxByte,
  input logic [ADDR_W-1:0] ownAddr,
  input logic              tenBitMode,
  input logic              rbwWr,
  input logic              rbwWrData,
  input logic              addrMatch,
  input logic              genCall,
  input logic              irqPulse,
  input logic              rbwOut
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(addrMatch && genCall)); // R12
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (addrMatch || genCall)); // R12
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R10
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (!addrMatch && !genCall && !irqPulse)); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (!addrMatch && !genCall && !irqPulse)); // R9
  AST_RBW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    rbwWr |=> (rbwOut == $past(rbwWrData))); // R7
  AST_RBW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rbwWr |=> $stable(rbwOut)); // R7
  AST_GC_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !startEv && !stopEv && rxByte != '0) |=> !$rose(genCall)); // R4
endmodule

bind slave_addr_recognizer slave_addr_recognizer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
  .byteValid(byteValid), .rxByte(rxByte), .ownAddr(ownAddr),
  .tenBitMode(tenBitMode), .rbwWr(rbwWr), .rbwWrData(rbwWrData),
  .addrMatch(addrMatch), .genCall(genCall), .irqPulse(irqPulse),
  .rbwOut(rbwOut)
);

// File: tb/slave_addr_recognizer_bench.sv
module slave_addr_recognizer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startEv = 1'b0, stopEv = 1'b0, byteValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic [6:0] ownAddr = 7'h5A;
  logic       tenBitMode = 1'b0, rbwWr = 1'b0, rbwWrData = 1'b0;
  logic       addrMatch, genCall, irqPulse, rbwOut;

  int checks = 0, errors = 0;
  string tag = "R11";
  bit mMatch = 0, mGc = 0, mIrq = 0, mRbw = 0, mArm = 0;

  always #4 clk = ~clk;

  slave_addr_recognizer u_slave_addr_recognizer (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .byteValid(byteValid), .rxByte(rxByte), .ownAddr(ownAddr),
    .tenBitMode(tenBitMode), .rbwWr(rbwWr), .rbwWrData(rbwWrData),
    .addrMatch(addrMatch), .genCall(genCall), .irqPulse(irqPulse),
    .rbwOut(rbwOut)
  );

  task automatic cmp(input string what, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // advance one clock, update the behavioural model, then compare
  task automatic tick();
    bit oldRbw, gc, hit;
    @(posedge clk);
    oldRbw = mRbw;
    if (!rstN) begin
      mMatch = 0; mGc = 0; mIrq = 0; mRbw = 0; mArm = 0;
    end else begin
      mIrq = 0;
      if (rbwWr) mRbw = rbwWrData;
      if (stopEv) begin
        mMatch = 0; mGc = 0; mArm = 0;
      end else if (startEv) begin
        mMatch = 0; mGc = 0; mArm = 1;
      end else if (byteValid && mArm) begin
        mArm = 0;
        gc  = (rxByte == 8'h00);
        hit = !gc && (rxByte[7:1] == ownAddr) && (!tenBitMode || rxByte[0] == oldRbw);
        mGc = gc; mMatch = hit; mIrq = gc || hit;
      end
    end
    #2;
    cmp("addrMatch", addrMatch, mMatch);
    cmp("genCall", genCall, mGc);
    cmp("irqPulse", irqPulse, mIrq);
    cmp("rbwOut", rbwOut, mRbw);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic doStart();
    startEv = 1; tick(); startEv = 0;
  endtask

  task automatic doStop();
    stopEv = 1; tick(); stopEv = 0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxByte = b; byteValid = 1; tick(); byteValid = 0;
  endtask

  task automatic writeRbw(input logic v);
    rbwWr = 1; rbwWrData = v; tick(); rbwWr = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tag = "R11"; idle(3);
    rstN = 1; idle(1);
    // R6: byte before any START ignored
    tag = "R6"; sendByte({7'h5A, 1'b0}); idle(1);
    // R1: 7-bit match, R/W = 0 and R/W = 1; R3 timing via model
    tag = "R1"; doStart(); sendByte({7'h5A, 1'b0}); idle(2);
    tag = "R3"; doStart(); sendByte({7'h5A, 1'b1}); idle(1);
    // R10: further bytes in same phase give no second pulse
    tag = "R10"; sendByte({7'h5A, 1'b1}); sendByte(8'h00); idle(1);
    tag = "R8"; doStop(); idle(1);
    // R5: mismatch
    tag = "R5"; doStart(); sendByte({7'h5B, 1'b0}); idle(1);
    tag = "R6"; sendByte({7'h5A, 1'b0}); idle(1);
    // R4: general call
    tag = "R4"; doStop(); doStart(); sendByte(8'h00); idle(2);
    tag = "R4"; doStart(); sendByte(8'h01); idle(1);
    // R2: 10-bit mode, RBW = 0
    tenBitMode = 1;
    tag = "R2"; doStart(); sendByte({7'h5A, 1'b1}); idle(1);
    doStart(); sendByte({7'h5A, 1'b0}); idle(1);
    sendByte(8'hC3); idle(1);               // second byte, ignored
    tag = "R7"; writeRbw(1); idle(1);
    tag = "R2"; doStart(); sendByte({7'h5A, 1'b1}); idle(1);
    doStart(); sendByte({7'h5A, 1'b0}); idle(1);
    // R2: RBW write in the same cycle as evaluation uses the old value
    tag = "R2"; doStart();
    rbwWr = 1; rbwWrData = 0; rxByte = {7'h5A, 1'b1}; byteValid = 1; tick();
    rbwWr = 0; byteValid = 0; idle(1);
    // R8: STOP beats START and byte together
    tag = "R8"; doStart();
    stopEv = 1; startEv = 1; rxByte = {7'h5A, 1'b0}; byteValid = 1; tick();
    stopEv = 0; startEv = 0; byteValid = 0; idle(1);
    tag = "R8"; sendByte({7'h5A, 1'b0}); idle(1);
    // R9: START with a byte in the same cycle ignores the byte
    tag = "R9"; doStart(); sendByte({7'h5A, 1'b0});
    startEv = 1; rxByte = {7'h5A, 1'b0}; byteValid = 1; tick();
    startEv = 0; byteValid = 0; idle(1);
    sendByte({7'h5A, 1'b0}); idle(1);
    // R12 / R1 with a different own address in 7-bit mode
    tenBitMode = 0; ownAddr = 7'h01;
    tag = "R12"; doStart(); sendByte(8'h03); idle(1);
    doStart(); sendByte(8'h00); idle(1);
    // R11: reset mid-phase clears flags and RBW
    writeRbw(1); doStart(); sendByte(8'h02);
    tag = "R11"; rstN = 0; idle(2); rstN = 1; idle(1);
    sendByte(8'h02); idle(1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule